// File: doc/BRIEF.md
# Strobe-Framed Serial Voice Word Port

This block is the serial edge of one direction of a voice transcoder. On the input side, an external bit clock carries a serial word, and a rising edge on an input strobe marks where the word begins. The port collects the word on the falling edges of that clock and passes it across to a faster internal processing clock. There it appears as a parallel word with a one-cycle valid pulse. On the output side, the core hands back a parallel result word. The port keeps that word in a second buffer that the bit-clock domain owns. When a rising edge on an output strobe requests a word, the port shifts it out on the rising edges of the bit clock. The data pin is driven only while a word is being shifted out; at every other time the drive-enable output is low, so the pad is high-impedance.

A mode input chooses between two companding conventions. In the mu-law convention, bits pass through unchanged. In the A-law convention, the even-numbered bits of every PCM word are inverted at the port, in both directions. When the reset input is low, the port sits idle. After reset is released, it outputs a fixed idle code instead of core data until four input frames have been captured. The word length is a parameter: 8 for PCM and 4 for ADPCM.

The input shifter has two states. RX_IDLE goes to RX_SHIFT when a strobe rise is seen, and RX_SHIFT goes back to RX_IDLE when the last bit is taken. The output shifter has two states. TX_IDLE goes to TX_DRIVE when a request rise is seen, and TX_DRIVE goes back to TX_IDLE after the last bit period. The warm-up gate has two states. GATE_MUTE goes to GATE_LIVE when the frame after the warm-up count is captured. Only reset takes the gate back to GATE_MUTE.

Top module: `vw_serial_port`

## Requirements
- R1: After `in_strobe` is sampled high on a falling `bit_clk` edge, having been sampled low on the previous falling edge, that edge and the next W-1 falling edges each take one bit from `ser_in`, MSB first. The assembled word then appears on `rx_word` in the `clk` domain.
- R2: When `alaw_mode` is 1, the port XORs each word with a mask that has bits 0, 2, 4 and 6 set (0x55 for 8 bits, LSB = bit 0). This applies both on `rx_word` and on the serial output. When `alaw_mode` is 0, words pass through unchanged.
- R3: The first rising `bit_clk` edge at which `out_strobe` is sampled high, after being sampled low, launches the MSB of the buffered output word on `ser_out`. Each of the next W-1 rising edges launches the next lower bit.
- R4: `ser_drive` is high for exactly W bit-clock periods per request and low at all other times.
- R5: After reset release, each word published for the first four captured frames is the idle code: all ones in mu-law mode, 0xD5 in A-law mode. From the fifth captured frame on, each `tx_valid` publishes the core word, with the R2 mask applied.
- R6: While `rst_n` is low, `ser_drive` stays low and `rx_valid` never pulses, even if both strobes toggle. When `rst_n` is released, the four-frame warm-up of R5 starts again.
- R7: A `tx_valid` that arrives while a word is being shifted out does not change that word. The next request carries the new word.
- R8: `rx_valid` is a single-cycle pulse, given once for each captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processing clock |
| rst_n | input | 1 | Active-low reset and power-down |
| alaw_mode | input | 1 | 1 selects A-law with even-bit inversion; 0 selects mu-law |
| bit_clk | input | 1 | External serial bit clock |
| in_strobe | input | 1 | Rising edge starts an input word |
| ser_in | input | 1 | Serial input data |
| out_strobe | input | 1 | Rising edge requests an output word |
| ser_out | output | 1 | Serial output data |
| ser_drive | output | 1 | Pad drive enable; low means high-impedance |
| rx_word | output | W | Captured parallel word in the `clk` domain |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_word` |
| tx_word | input | W | Core result word |
| tx_valid | input | 1 | Publishes `tx_word` to the output buffer |

## Verification
The hardest case to reach from the ports is a core word that lands while another word is partway out of the shifter. That needs a `tx_valid` pulse timed inside one particular bit-clock period. The bench reaches it from inside its serial read task: half-way through the word, it fires `tx_valid` on the internal clock. It then checks that the word in flight is unchanged and that the next request carries the new word. The four-frame warm-up is covered by starting the vector walk directly after reset, so the first four frames must return idle codes in both modes. A second reset in the middle of the run shows that the warm-up starts over.

// File: rtl/vw_pkg.sv
package vw_pkg;
    typedef enum logic {RX_IDLE, RX_SHIFT}    rx_state_e;
    typedef enum logic {TX_IDLE, TX_DRIVE}    tx_state_e;
    typedef enum logic {GATE_MUTE, GATE_LIVE} gate_state_e;

    // alternating mask, bit 0 set; truncated to the word width
    localparam logic [31:0] EVEN_BITS = 32'h5555_5555;
endpackage

// File: rtl/vw_rx_shift.sv
module vw_rx_shift
    import vw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         bit_clk,
    input  logic         rst_n,
    input  logic         in_strobe,
    input  logic         ser_in,
    output logic [W-1:0] cap_word,
    output logic         cap_tgl
);
    localparam int CW = $clog2(W);

    rx_state_e     state_q, state_d;
    logic          strobe_q;
    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          start;
    logic          last;

    assign start = in_strobe && !strobe_q;
    assign last  = (cnt_q == CW'(W - 1));

    // state register (falling edge domain)
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (start) state_d = RX_SHIFT;
            RX_SHIFT: if (last)  state_d = RX_IDLE;
        endcase
    end

    // datapath
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            sh_q     <= '0;
            cnt_q    <= '0;
            cap_word <= '0;
            cap_tgl  <= 1'b0;
        end else begin
            strobe_q <= in_strobe;
            unique case (state_q)
                RX_IDLE: begin
                    if (start) begin
                        sh_q  <= {sh_q[W-2:0], ser_in};
                        cnt_q <= CW'(1);
                    end
                end
                RX_SHIFT: begin
                    sh_q  <= {sh_q[W-2:0], ser_in};
                    cnt_q <= cnt_q + 1'b1;
                    if (last) begin
                        cap_word <= {sh_q[W-2:0], ser_in};
                        cap_tgl  <= ~cap_tgl;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vw_frame_gate.sv
module vw_frame_gate
    import vw_pkg::*;
#(
    parameter int           W      = 8,
    parameter int           WARM   = 4,
    parameter logic [W-1:0] MASK   = '0,
    parameter logic [W-1:0] IDLE_A = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         alaw_mode,
    input  logic [W-1:0] cap_word,
    input  logic         cap_tgl,
    input  logic [W-1:0] tx_word,
    input  logic         tx_valid,
    output logic [W-1:0] rx_word,
    output logic         rx_valid,
    output logic [W-1:0] pub_word,
    output logic         pub_tgl,
    output logic         live
);
    localparam int GW = $clog2(WARM + 1);

    gate_state_e   state_q, state_d;
    logic [2:0]    sync_q;
    logic          evt;
    logic [GW-1:0] frames_q;
    logic [W-1:0]  mask_sel;
    logic [W-1:0]  idle_code;

    assign evt       = sync_q[1] ^ sync_q[2];
    assign mask_sel  = alaw_mode ? MASK : '0;
    assign idle_code = alaw_mode ? IDLE_A : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_MUTE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_MUTE: if (evt && frames_q == GW'(WARM)) state_d = GATE_LIVE;
            GATE_LIVE: state_d = GATE_LIVE;
        endcase
    end

    assign live = (state_q == GATE_LIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '0;
            frames_q <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
            pub_word <= '1;
            pub_tgl  <= 1'b0;
        end else begin
            sync_q   <= {sync_q[1:0], cap_tgl};
            rx_valid <= evt;
            if (evt) begin
                rx_word <= cap_word ^ mask_sel;
                if (state_q == GATE_MUTE && frames_q != GW'(WARM))
                    frames_q <= frames_q + 1'b1;
            end
            if (tx_valid) begin
                pub_word <= live ? (tx_word ^ mask_sel) : idle_code;
                pub_tgl  <= ~pub_tgl;
            end
        end
    end
endmodule

// File: rtl/vw_tx_shift.sv
module vw_tx_shift
    import vw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         bit_clk,
    input  logic         rst_n,
    input  logic         out_strobe,
    input  logic [W-1:0] pub_word,
    input  logic         pub_tgl,
    output logic         ser_out,
    output logic         ser_drive
);
    localparam int CW = $clog2(W);

    tx_state_e     state_q, state_d;
    logic          strobe_q;
    logic [2:0]    sync_q;
    logic [W-1:0]  buf_q;
    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          start;
    logic          last;

    assign start = out_strobe && !strobe_q;
    assign last  = (cnt_q == CW'(W - 1));

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (start) state_d = TX_DRIVE;
            TX_DRIVE: if (last)  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            sync_q   <= '0;
            buf_q    <= '1;
            sh_q     <= '0;
            cnt_q    <= '0;
        end else begin
            strobe_q <= out_strobe;
            sync_q   <= {sync_q[1:0], pub_tgl};
            if (sync_q[1] ^ sync_q[2]) buf_q <= pub_word;
            unique case (state_q)
                TX_IDLE: begin
                    if (start) begin
                        sh_q  <= buf_q;
                        cnt_q <= '0;
                    end
                end
                TX_DRIVE: begin
                    sh_q  <= sh_q << 1;
                    cnt_q <= cnt_q + 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ser_drive = (state_q == TX_DRIVE);
        ser_out   = ser_drive ? sh_q[W-1] : 1'b0;
    end
endmodule

// File: rtl/vw_serial_port.sv
module vw_serial_port
    import vw_pkg::*;
#(
    parameter int           W      = 8,
    parameter int           WARM   = 4,
    parameter bit           PCM    = 1'b1,
    parameter logic [W-1:0] IDLE_A = W'(8'hD5)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         alaw_mode,
    input  logic         bit_clk,
    input  logic         in_strobe,
    input  logic         ser_in,
    input  logic         out_strobe,
    output logic         ser_out,
    output logic         ser_drive,
    output logic [W-1:0] rx_word,
    output logic         rx_valid,
    input  logic [W-1:0] tx_word,
    input  logic         tx_valid
);
    localparam logic [W-1:0] MASK = PCM ? EVEN_BITS[W-1:0] : '0;

    logic [W-1:0] cap_word;
    logic         cap_tgl;
    logic [W-1:0] pub_word;
    logic         pub_tgl;
    logic         live;

    vw_rx_shift #(.W(W)) u_rx (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .in_strobe(in_strobe),
        .ser_in   (ser_in),
        .cap_word (cap_word),
        .cap_tgl  (cap_tgl)
    );

    vw_frame_gate #(.W(W), .WARM(WARM), .MASK(MASK), .IDLE_A(IDLE_A)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .alaw_mode(alaw_mode),
        .cap_word (cap_word),
        .cap_tgl  (cap_tgl),
        .tx_word  (tx_word),
        .tx_valid (tx_valid),
        .rx_word  (rx_word),
        .rx_valid (rx_valid),
        .pub_word (pub_word),
        .pub_tgl  (pub_tgl),
        .live     (live)
    );

    vw_tx_shift #(.W(W)) u_tx (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .out_strobe(out_strobe),
        .pub_word  (pub_word),
        .pub_tgl   (pub_tgl),
        .ser_out   (ser_out),
        .ser_drive (ser_drive)
    );
endmodule

// File: rtl/vw_port_checker.sv
module vw_port_checker #(
    parameter int           W      = 8,
    parameter int           WARM   = 4,
    parameter logic [W-1:0] IDLE_A = '1
) (
    input logic         clk,
    input logic         bit_clk,
    input logic         rst_n,
    input logic         alaw_mode,
    input logic         rx_valid,
    input logic         tx_valid,
    input logic         ser_drive,
    input logic         live,
    input logic [W-1:0] pub_word
);
    logic [7:0] seen_q;
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         seen_q <= '0;
        else if (rx_valid && seen_q != 8'hFF) seen_q <= seen_q + 1'b1;
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (ser_drive) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_drive_len_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        run_q <= 8'(W));

    assert_mute_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && tx_valid) |=> pub_word == ($past(alaw_mode) ? IDLE_A : {W{1'b1}}));

    assert_live_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> live);

    assert_warm_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (seen_q + {7'd0, rx_valid}) > 8'(WARM));
endmodule

bind vw_serial_port vw_port_checker #(.W(W), .WARM(WARM), .IDLE_A(IDLE_A)) u_chk (
    .clk      (clk),
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .alaw_mode(alaw_mode),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .ser_drive(ser_drive),
    .live     (live),
    .pub_word (pub_word)
);

// File: tb/tb_vw_serial_port.sv
module tb_vw_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_PERIOD = 80;
    localparam int NV = 10;

    // {mode, serial input word, core result word}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'hA7, 8'h3C}, {1'b1, 8'h5A, 8'hC3}, {1'b0, 8'h00, 8'hFF},
        {1'b1, 8'hFF, 8'h00}, {1'b0, 8'h81, 8'h7E}, {1'b1, 8'hAA, 8'h55},
        {1'b0, 8'h13, 8'hE4}, {1'b1, 8'hD5, 8'h2B}, {1'b0, 8'h6C, 8'h91},
        {1'b1, 8'hF0, 8'h0F}
    };

    logic clk = 0, bit_clk = 0, rst_n = 0, alaw_mode = 0;
    logic in_strobe = 0, ser_in = 0, out_strobe = 0, tx_valid = 0;
    logic [7:0] tx_word = '0;
    logic ser_out, ser_drive, rx_valid;
    logic [7:0] rx_word;

    int checks = 0, errors = 0, got_cnt = 0;
    logic [7:0] got_word = '0;

    vw_serial_port dut (
        .clk(clk), .rst_n(rst_n), .alaw_mode(alaw_mode), .bit_clk(bit_clk),
        .in_strobe(in_strobe), .ser_in(ser_in), .out_strobe(out_strobe),
        .ser_out(ser_out), .ser_drive(ser_drive), .rx_word(rx_word),
        .rx_valid(rx_valid), .tx_word(tx_word), .tx_valid(tx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(BIT_PERIOD/2) bit_clk = ~bit_clk;

    always @(negedge clk) if (rx_valid === 1'b1) begin
        got_word = rx_word;
        got_cnt++;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] msk(input logic m);
        return m ? 8'h55 : 8'h00;
    endfunction

    task automatic send_word(input logic [7:0] w);
        @(posedge bit_clk); #1 in_strobe = 1; ser_in = w[7];
        for (int i = 6; i >= 0; i--) begin
            @(posedge bit_clk); #1 ser_in = w[i];
        end
        @(posedge bit_clk); #1 in_strobe = 0;
    endtask

    task automatic post_tx(input logic [7:0] w);
        @(negedge clk); tx_word = w; tx_valid = 1;
        @(negedge clk); tx_valid = 0;
        repeat (6) @(posedge bit_clk);
    endtask

    // read one serial word; optionally publish a new core word mid-shift
    task automatic get_word(output logic [7:0] r, input bit inject, input logic [7:0] nw);
        logic drv_ok;
        drv_ok = 1;
        @(posedge bit_clk); #1 out_strobe = 1;
        for (int i = 7; i >= 0; i--) begin
            @(posedge bit_clk); #5 r[i] = ser_out;
            if (ser_drive !== 1'b1) drv_ok = 0;
            if (inject && i == 4) begin
                @(negedge clk); tx_word = nw; tx_valid = 1;
                @(negedge clk); tx_valid = 0;
            end
        end
        chk("R4 drive during word", {7'd0, drv_ok}, 8'd1);
        @(posedge bit_clk); #5;
        chk("R4 high-Z after word", {7'd0, ser_drive}, 8'd0);
        out_strobe = 0;
    endtask

    task automatic frame(input logic m, input logic [7:0] in_w, input logic [7:0] tx_w,
                         input logic [7:0] exp_out);
        int prev;
        logic [7:0] r;
        alaw_mode = m;
        prev = got_cnt;
        send_word(in_w);
        repeat (20) @(negedge clk);
        chk("R8 one rx pulse per word", 8'(got_cnt - prev), 8'd1);
        chk("R1/R2 captured word", got_word, in_w ^ msk(m));
        post_tx(tx_w);
        get_word(r, 0, 8'h00);
        chk("R3/R5 serial output word", r, exp_out);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int prev;
        repeat (5) @(negedge clk);
        chk("R6 reset drive", {7'd0, ser_drive}, 8'd0);
        chk("R6 reset rx_valid", {7'd0, rx_valid}, 8'd0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        // vector walk: first four frames are inside warm-up (R5)
        for (int k = 0; k < NV; k++) begin
            logic m;
            logic [7:0] exp_o;
            m = VEC[k][16];
            if (k < 4) exp_o = m ? 8'hD5 : 8'hFF;
            else       exp_o = VEC[k][7:0] ^ msk(m);
            frame(m, VEC[k][15:8], VEC[k][7:0], exp_o);
        end

        // R7: core word arriving mid-shift must not disturb the word in flight
        alaw_mode = 1;
        get_word(r, 1, 8'h3E);
        chk("R7 word in flight kept", r, 8'h0F ^ 8'h55);
        repeat (6) @(posedge bit_clk);
        get_word(r, 0, 8'h00);
        chk("R7 next request carries new word", r, 8'h3E ^ 8'h55);

        // R6: reset mid-run, strobes toggling
        @(negedge clk); rst_n = 0;
        prev = got_cnt;
        fork
            send_word(8'h99);
            begin
                @(posedge bit_clk); #1 out_strobe = 1;
                repeat (10) begin
                    @(posedge bit_clk); #5;
                    if (ser_drive !== 1'b0) chk("R6 no drive in reset", {7'd0, ser_drive}, 8'd0);
                end
                out_strobe = 0;
            end
        join
        repeat (20) @(negedge clk);
        chk("R6 no capture in reset", 8'(got_cnt - prev), 8'd0);
        chk("R6 drive low in reset", {7'd0, ser_drive}, 8'd0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        // R5/R6: warm-up restarts, mu-law idle code
        frame(1'b0, 8'h42, 8'h99, 8'hFF);
        // still warm-up, A-law idle code
        frame(1'b1, 8'h24, 8'h66, 8'hD5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule